// File: doc/BRIEF.md
# Keyboard Matrix Scanner Encoder

This block watches a grid of key switches. It pulls one row line low at a time, and it walks the rows in a fixed repeating order. While a row is pulled low, it reads the column lines back through a two-flop synchroniser. A column that reads low means the switch at that row and column is closed. The block looks at one key position per clock cycle during a visit window.

When a new closure is seen, the key gets a debounce slot. A timer in that slot runs for a programmable number of cycles. At the first visit after the timer expires, the key is reported only if it still reads closed. A report places a row/column index code on the output, raises a strobe for one cycle, and sets a sticky flag that the host clears.

Two slots let a second key be caught while the first is still debouncing. Both keys are then reported in the order in which they were first seen. A key that stays down is reported once. It must be seen open again before it can be reported a second time. At most two keys are tracked at once, counting held keys and keys in debounce. Any further key is ignored until one of the tracked keys is released.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: While reset is high and at the first cycle after it: `rowN` equals all ones except bit 0, which is low (row 0 driven). `keyStrobe`, `keyFlag` and `keyCode` are all zero.
- R2: Exactly one bit of `rowN` is low in every cycle. Each row stays driven for COLS+2 consecutive cycles. The rows are driven in ascending index order and wrap from the last row to row 0.
- R3: A closure is reported only if it reads closed at a visit made at least DEBOUNCE cycles after the visit that first saw it. A closure that opens again before that visit produces no report.
- R4: A lone key that stays pressed produces its strobe between DEBOUNCE and DEBOUNCE+2*FRAME+4 cycles after the press, where FRAME = ROWS*(COLS+2).
- R5: `keyStrobe` is high for exactly one cycle per report, and two strobes are never in adjacent cycles. `keyCode` changes only in a strobe cycle. The code holds the column index in bits [COL_W-1:0] and the row index in the next ROW_W bits, and all higher bits are zero.
- R6: `keyFlag` is high in every strobe cycle. It stays high until `clrFlag` is sampled high at a clock edge with no report at that edge, and it is low in the cycle after that edge.
- R7: When a second key closes while the first is still being debounced, both are reported. The key first seen by the scan is reported first, including when the second key is visited earlier in the scan order.
- R8: A key held for many scan frames is reported once. After it is seen released and is pressed again, it is reported again.
- R9: No more than two keys are tracked, counting held keys and keys in debounce. A third key pressed while two are held is not reported. After one of the two is released, the third key is reported if it is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| colN | input | COLS | Column sense lines; low means closed in the driven row |
| clrFlag | input | 1 | Host clears the key flag |
| rowN | output | ROWS | Row drive; the single low bit is the scanned row |
| keyCode | output | 8 | Index code {row, column}, zero-padded |
| keyStrobe | output | 1 | One-cycle pulse marking a new code |
| keyFlag | output | 1 | Sticky flag set with each report |

## Verification
A report appears one clock after the visit that confirms the key. That visit itself falls somewhere in a window, set by the debounce length and up to two scan frames, after the press. For this reason the bench logs every strobe with its cycle number at the falling edge. It then judges the order and count of codes after a 200-cycle quiet period, and checks the latency of a lone key against the R4 window instead of one exact cycle. The flag drop is due one edge after `clrFlag`, so it is sampled at the next falling edge. Row timing is checked cycle by cycle over two frames, starting from a row-3-to-row-0 transition.

// File: rtl/kbdscan_pkg.sv
package kbdscan_pkg;
  localparam int CODE_W = 8;
  typedef logic [CODE_W-1:0] keyCode_t;

  // one key position looked at by the datapath this cycle
  typedef struct packed {
    logic     visit;
    logic     pressed;
    keyCode_t key;
  } scanTap_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     report;
    keyCode_t key;
  } ctrlCmd_t;
endpackage

// File: rtl/kbdscan_datapath.sv
module kbdscan_datapath
  import kbdscan_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int ROW_W = 2,
  parameter int COL_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [COLS-1:0] colN,
  input  logic            clrFlag,
  input  ctrlCmd_t        cmd,
  output logic [ROWS-1:0] rowN,
  output scanTap_t        tap,
  output keyCode_t        keyCode,
  output logic            keyStrobe,
  output logic            keyFlag
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [1:0]       SETTLE   = 2'd2;

  logic [ROW_W-1:0] rowIdx;
  logic [COL_W-1:0] colIdx;
  logic [1:0]       settleCnt;
  logic [COLS-1:0]  colSync;
  logic             visiting;

  assign visiting = (settleCnt == SETTLE);

  // scan sequencer: two settle cycles, then one cycle per column
  always_ff @(posedge clk) begin
    if (rst) begin
      rowIdx    <= '0;
      colIdx    <= '0;
      settleCnt <= '0;
    end else if (!visiting) begin
      settleCnt <= settleCnt + 2'd1;
    end else if (colIdx == COL_LAST) begin
      colIdx    <= '0;
      settleCnt <= '0;
      rowIdx    <= (rowIdx == ROW_LAST) ? '0 : rowIdx + ROW_W'(1);
    end else begin
      colIdx <= colIdx + COL_W'(1);
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_rowDrive
    assign rowN[r] = (rowIdx != ROW_W'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_colSync
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1 <= 1'b1;
        stage2 <= 1'b1;
      end else begin
        stage1 <= colN[c];
        stage2 <= stage1;
      end
    end
    assign colSync[c] = stage2;
  end

  assign tap.visit   = visiting;
  assign tap.pressed = ~colSync[colIdx];
  assign tap.key     = keyCode_t'({rowIdx, colIdx});

  // output register, strobe and sticky flag
  always_ff @(posedge clk) begin
    if (rst) begin
      keyCode   <= '0;
      keyStrobe <= 1'b0;
      keyFlag   <= 1'b0;
    end else begin
      keyStrobe <= cmd.report;
      if (cmd.report) begin
        keyCode <= cmd.key;
        keyFlag <= 1'b1;
      end else if (clrFlag) begin
        keyFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kbdscan_control.sv
module kbdscan_control
  import kbdscan_pkg::*;
#(
  parameter int DEBOUNCE = 500000,
  parameter int KEY_W    = 4,
  parameter int NKEYS    = 16,
  parameter int CNT_W    = 5,
  parameter int TMR_W    = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  scanTap_t         tap,
  output ctrlCmd_t         cmd,
  output logic [CNT_W-1:0] trackCnt
);
  localparam int NSLOT = 2;

  logic [NKEYS-1:0] held;
  logic [NSLOT-1:0] slotValid;
  keyCode_t         slotKey [NSLOT];
  logic [TMR_W-1:0] slotTmr [NSLOT];
  logic             oldSlot;
  logic             justReported;

  logic [NSLOT-1:0] hit;
  logic             anyHit, hitSlot, hitDone;
  logic             report, freeSlot, alloc, allocSlot;
  logic [KEY_W-1:0] keyIdx;
  logic [CNT_W-1:0] heldCnt, tracked;

  function automatic logic [CNT_W-1:0] countSet(input logic [NKEYS-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NKEYS; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  assign keyIdx  = tap.key[KEY_W-1:0];
  assign heldCnt = countSet(held);
  assign tracked = heldCnt + CNT_W'(slotValid[0]) + CNT_W'(slotValid[1]);
  assign trackCnt = tracked;

  for (genvar s = 0; s < NSLOT; s++) begin : g_hit
    assign hit[s] = tap.visit && slotValid[s] && (slotKey[s] == tap.key);
  end

  assign anyHit  = |hit;
  assign hitSlot = hit[1];
  assign hitDone = (slotTmr[hitSlot] == '0);

  always_comb begin
    report    = 1'b0;
    freeSlot  = 1'b0;
    alloc     = 1'b0;
    allocSlot = slotValid[0];
    if (anyHit && hitDone) begin
      if (!tap.pressed) begin
        freeSlot = 1'b1;
      end else if (!justReported &&
                   (!slotValid[~hitSlot] || (oldSlot == hitSlot))) begin
        report   = 1'b1;
        freeSlot = 1'b1;
      end
    end
    if (tap.visit && !anyHit && tap.pressed && !held[keyIdx] &&
        (tracked < CNT_W'(NSLOT)))
      alloc = 1'b1;
  end

  assign cmd.report = report;
  assign cmd.key    = tap.key;

  always_ff @(posedge clk) begin
    if (rst) begin
      held         <= '0;
      slotValid    <= '0;
      oldSlot      <= 1'b0;
      justReported <= 1'b0;
      for (int s = 0; s < NSLOT; s++) begin
        slotKey[s] <= '0;
        slotTmr[s] <= '0;
      end
    end else begin
      justReported <= report;
      if (tap.visit) begin
        if (report)            held[keyIdx] <= 1'b1;
        else if (!tap.pressed) held[keyIdx] <= 1'b0;
      end
      for (int s = 0; s < NSLOT; s++) begin
        if (slotValid[s] && (slotTmr[s] != '0))
          slotTmr[s] <= slotTmr[s] - TMR_W'(1);
      end
      if (freeSlot) begin
        slotValid[hitSlot] <= 1'b0;
        oldSlot            <= ~hitSlot;
      end
      if (alloc) begin
        slotValid[allocSlot] <= 1'b1;
        slotKey[allocSlot]   <= tap.key;
        slotTmr[allocSlot]   <= TMR_W'(DEBOUNCE);
        oldSlot              <= slotValid[~allocSlot] ? ~allocSlot : allocSlot;
      end
    end
  end
endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
  import kbdscan_pkg::*;
#(
  parameter int ROWS     = 4,
  parameter int COLS     = 4,
  parameter int DEBOUNCE = 500000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [COLS-1:0]     colN,
  input  logic                clrFlag,
  output logic [ROWS-1:0]     rowN,
  output logic [CODE_W-1:0]   keyCode,
  output logic                keyStrobe,
  output logic                keyFlag
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int KEY_W = ROW_W + COL_W;
  localparam int NKEYS = 1 << KEY_W;
  localparam int CNT_W = $clog2(NKEYS + 3);
  localparam int TMR_W = $clog2(DEBOUNCE + 1);

  scanTap_t         tap;
  ctrlCmd_t         cmd;
  logic [CNT_W-1:0] trackCnt;

  kbdscan_datapath #(
    .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)
  ) dpath (
    .clk(clk), .rst(rst), .colN(colN), .clrFlag(clrFlag), .cmd(cmd),
    .rowN(rowN), .tap(tap), .keyCode(keyCode), .keyStrobe(keyStrobe),
    .keyFlag(keyFlag)
  );

  kbdscan_control #(
    .DEBOUNCE(DEBOUNCE), .KEY_W(KEY_W), .NKEYS(NKEYS), .CNT_W(CNT_W),
    .TMR_W(TMR_W)
  ) ctrl (
    .clk(clk), .rst(rst), .tap(tap), .cmd(cmd), .trackCnt(trackCnt)
  );
endmodule

// File: rtl/kbd_matrix_scanner_chk.sv
module kbd_matrix_scanner_chk #(
  parameter int ROWS  = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             clrFlag,
  input logic [ROWS-1:0]  rowN,
  input logic [7:0]       keyCode,
  input logic             keyStrobe,
  input logic             keyFlag,
  input logic [CNT_W-1:0] trackCnt
);
  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!keyStrobe && !keyFlag && keyCode == 8'h00));

  // R2
  row_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~rowN) == 1);

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    keyStrobe |=> !keyStrobe);

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !keyStrobe |-> $stable(keyCode));

  // R6
  flag_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    keyStrobe |-> keyFlag);

  // R6
  flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(keyFlag) |-> $past(clrFlag));

  // R9
  track_limit_chk: assert property (@(posedge clk) disable iff (rst)
    trackCnt <= CNT_W'(2));
endmodule

bind kbd_matrix_scanner kbd_matrix_scanner_chk #(
  .ROWS(ROWS), .CNT_W(CNT_W)
) chkInst (
  .clk(clk), .rst(rst), .clrFlag(clrFlag), .rowN(rowN), .keyCode(keyCode),
  .keyStrobe(keyStrobe), .keyFlag(keyFlag), .trackCnt(trackCnt)
);

// File: tb/kbd_matrix_scanner_test.sv
module kbd_matrix_scanner_test;
  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int DEB   = 40;
  localparam int FRAME = ROWS * (COLS + 2);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            clrFlag = 1'b0;
  logic [COLS-1:0] colN;
  logic [ROWS-1:0] rowN;
  logic [7:0]      keyCode;
  logic            keyStrobe, keyFlag;
  logic [15:0]     keysDown = '0;

  int nChk = 0, nFail = 0;
  int cyc = 0;
  int nRep = 0;
  int strobeViol = 0, flagViol = 0;
  logic prevStrobe = 1'b0;
  logic [7:0] repLog [32];
  int         repCyc [32];

  always #10 clk = ~clk;

  kbd_matrix_scanner #(.ROWS(ROWS), .COLS(COLS), .DEBOUNCE(DEB)) uut (
    .clk(clk), .rst(rst), .colN(colN), .clrFlag(clrFlag), .rowN(rowN),
    .keyCode(keyCode), .keyStrobe(keyStrobe), .keyFlag(keyFlag)
  );

  // switch matrix model: a closed key pulls its column low when its row is driven
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      colN[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (keysDown[r*COLS+c] && !rowN[r]) colN[c] = 1'b0;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (keyStrobe) begin
        if (nRep < 32) begin
          repLog[nRep] = keyCode;
          repCyc[nRep] = cyc;
        end
        nRep = nRep + 1;
        if (prevStrobe) strobeViol = strobeViol + 1;
        if (!keyFlag)   flagViol   = flagViol + 1;
      end
      prevStrobe = keyStrobe;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]  keyA;
    logic [7:0]  keyB;
    logic [7:0]  gap;
    logic [11:0] hold;
    logic [1:0]  expN;
  } vec_t;

  // code = row*4 + col; keyB 8'hFF means no second key
  localparam vec_t VEC [6] = '{
    '{8'h06, 8'hFF, 8'd0,  12'd200, 2'd1},
    '{8'h03, 8'h09, 8'd30, 12'd200, 2'd2},
    '{8'h0F, 8'h00, 8'd30, 12'd200, 2'd2},
    '{8'h05, 8'hFF, 8'd0,  12'd5,   2'd0},
    '{8'h0A, 8'h0B, 8'd30, 12'd200, 2'd2},
    '{8'h0C, 8'h0D, 8'd0,  12'd200, 2'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nFail + 1);
    $finish;
  end

  initial begin
    int base, pA, lat, rowErr;
    logic [ROWS-1:0] prevRow;

    repeat (4) @(negedge clk);
    check("R1 rowN", rowN, 4'b1110);
    check("R1 keyStrobe", keyStrobe, 0);
    check("R1 keyFlag", keyFlag, 0);
    check("R1 keyCode", keyCode, 0);
    rst = 1'b0;

    // R2: find a row3 -> row0 transition, then check two frames
    prevRow = rowN;
    @(negedge clk);
    while (!(prevRow == 4'b0111 && rowN == 4'b1110)) begin
      prevRow = rowN;
      @(negedge clk);
    end
    rowErr = 0;
    for (int k = 0; k < 2 * FRAME; k++) begin
      if (rowN !== ~(4'b0001 << ((k / (COLS + 2)) % ROWS))) rowErr++;
      @(negedge clk);
    end
    check("R2 row sequence errors", rowErr, 0);

    // vector table: R3 R4 R5 R7 R8
    for (int i = 0; i < 6; i++) begin
      base = nRep;
      @(negedge clk);
      keysDown[VEC[i].keyA[3:0]] = 1'b1;
      pA = cyc;
      if (VEC[i].keyB != 8'hFF) begin
        repeat (VEC[i].gap) @(negedge clk);
        keysDown[VEC[i].keyB[3:0]] = 1'b1;
      end
      repeat (VEC[i].hold) @(negedge clk);
      keysDown = '0;
      repeat (200) @(negedge clk);
      check($sformatf("R3 R7 R8 report count vec%0d", i), nRep - base, int'(VEC[i].expN));
      if (VEC[i].expN >= 1)
        check($sformatf("R5 R7 first code vec%0d", i), repLog[base], VEC[i].keyA);
      if (VEC[i].expN == 2)
        check($sformatf("R7 second code vec%0d", i), repLog[base+1], VEC[i].keyB);
      if (VEC[i].expN == 1 && VEC[i].keyB == 8'hFF) begin
        lat = repCyc[base] - pA;
        check("R4 latency in window", int'(lat >= DEB && lat <= DEB + 2*FRAME + 4), 1);
      end
    end

    check("R5 strobe width/adjacency violations", strobeViol, 0);
    check("R6 strobe without flag", flagViol, 0);

    // R6: flag remains set, then clears one edge after clrFlag
    check("R6 flag still set", keyFlag, 1);
    clrFlag = 1'b1;
    @(negedge clk);
    clrFlag = 1'b0;
    check("R6 flag cleared", keyFlag, 0);
    repeat (5) @(negedge clk);
    check("R6 flag stays clear", keyFlag, 0);

    // R8: release and press again gives a second report
    base = nRep;
    keysDown[6] = 1'b1;
    repeat (150) @(negedge clk);
    keysDown = '0;
    repeat (100) @(negedge clk);
    keysDown[6] = 1'b1;
    repeat (150) @(negedge clk);
    keysDown = '0;
    repeat (100) @(negedge clk);
    check("R8 re-press count", nRep - base, 2);
    check("R8 re-press code", repLog[base+1], 8'h06);

    // R9: third key ignored while two held, reported after a release
    base = nRep;
    keysDown[1] = 1'b1;
    repeat (150) @(negedge clk);
    keysDown[2] = 1'b1;
    repeat (150) @(negedge clk);
    keysDown[4] = 1'b1;
    repeat (200) @(negedge clk);
    check("R9 third key ignored", nRep - base, 2);
    keysDown[1] = 1'b0;
    repeat (200) @(negedge clk);
    check("R9 third key after release", nRep - base, 3);
    check("R9 third key code", repLog[base+2], 8'h04);
    keysDown = '0;
    repeat (100) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule